// File: doc/BRIEF.md
# DMA Burst Beat and Byte-Enable Generator

This block turns one memory burst request of a DMA engine into a stream of dword beats. Each request gives a region start address, the number of bytes still to move (a 16-bit count in which zero stands for 65536) and a direction. The block then issues one beat per clock. Each beat carries a dword address, four byte enables (bit 0 is the lowest-addressed byte) and a last flag. A burst never runs past the end of the 32-byte cache line in which it starts. It also stops early on the final dword that still holds valid data.

Reads always fetch whole dwords. Address bits 1:0 are forced to zero and every byte enable is asserted. Writes keep address bit 1. A word-offset start therefore disables the lower word on the first beat, and bytes that lie past the end of the data are disabled on the final beat. After the burst the block reports the remaining byte count, decreased by the bytes each beat covered. It raises a done indication when that count has reached zero. The caller issues the next burst from the following line.

The control is a three-state machine:
- IDLE waits for `start_i`. The transition IDLE→BEAT loads the address, count and direction.
- BEAT issues one beat per cycle. The transition BEAT→END is taken on the beat that has the last flag set.
- END pulses `burst_end_o` for one cycle, with `rem_o` and `region_done_o` valid. The transition END→IDLE is unconditional.

Top module: `dma_beat_gen`

## Requirements
- R1: A read burst (`write_i`=0) drives beat address bits 1:0 as 00 and byte enables 1111 on every beat.
- R2: A write burst keeps start address bit 1 (bit 0 is treated as 0). When bit 1 is set, the first beat has byte enables 1100; later beats start at offset 0.
- R3: A write whose data reaches at least to the end of the line, started at line offset 0, issues 8 beats at consecutive dword addresses with byte enables 1111.
- R4: A burst starting inside a 32-byte line ends at the last dword of that line, so no burst crosses a 32-byte boundary.
- R5: Write byte enables cover only valid bytes. When data ends at byte offset 1, 2 or 3 of a dword that starts at offset 0, the enables are 0001, 0011 or 0111. When a beat starts at offset 2 with one byte left, the enables are 0100.
- R6: No beat is issued after the last valid byte. `beat_last_o` is set on exactly the final beat of the burst.
- R7: During the END cycle, `rem_o` equals the loaded count minus the bytes covered. Writes subtract the enabled bytes; reads subtract the valid bytes of each beat. `region_done_o` is 1 in that cycle exactly when the remainder is zero.
- R8: A count input of 0 is loaded as 65536 bytes.
- R9: `start_i` and the request inputs are ignored while `busy_o` is 1.
- R10: After reset the block is idle: `busy_o`, `beat_valid_o`, `burst_end_o` and `region_done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a burst (taken only in IDLE) |
| write_i | input | 1 | 1 = memory write, 0 = memory read |
| addr_i | input | 32 | Region start byte address |
| count_i | input | 16 | Remaining bytes, 0 means 65536 |
| busy_o | output | 1 | State is BEAT or END |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_addr_o | output | 32 | Byte address of the beat |
| beat_be_o | output | 4 | Byte enables, bit 0 = lowest byte |
| beat_last_o | output | 1 | Final beat of the burst |
| burst_end_o | output | 1 | One-cycle pulse after the final beat |
| rem_o | output | 17 | Remaining byte count |
| region_done_o | output | 1 | Remainder is zero, valid with burst_end_o |

## Verification
The hardest case to reach from the ports is a write that starts at a word offset and whose data ends inside that same first dword. Here the leading mask and the trailing mask apply to one beat, which must also be the last one. Directed cases cover this case with a count of one and two bytes at odd-word addresses. Further directed cases cover all three trailing offsets and line-end stops from every dword slot. Random requests favour small counts and word-offset starts, so these overlaps recur many times. One directed burst toggles `start_i` and the request inputs while the burst is running.

// File: rtl/dma_beat_pkg.sv
package dma_beat_pkg;

    localparam int BE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_END  = 2'd2
    } beat_state_t;

    typedef logic [BE_W-1:0] be_t;

endpackage

// File: rtl/dma_beat_lane.sv
// Per-beat arithmetic: how many bytes this dword carries, which byte lanes
// are enabled, and whether the beat closes the burst.
module dma_beat_lane #(
    parameter int ADDR_W     = 32,
    parameter int REM_W      = 17,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0]  cur_addr_i,
    input  logic [REM_W-1:0]   rem_i,
    input  logic               write_i,
    output dma_beat_pkg::be_t  be_o,
    output logic [2:0]         nbytes_o,
    output logic               last_o
);
    import dma_beat_pkg::*;

    localparam int LINE_LSB = $clog2(LINE_BYTES);

    logic [1:0] off;
    logic [2:0] avail;
    logic [2:0] nb;
    be_t        mask;

    assign off = cur_addr_i[1:0];

    always_comb begin
        avail = 3'd4 - {1'b0, off};
        if (rem_i < REM_W'(avail)) begin
            nb = rem_i[2:0];
        end else begin
            nb = avail;
        end
    end

    always_comb begin
        for (int i = 0; i < BE_W; i++) begin
            mask[i] = (3'(i) >= {1'b0, off}) && (3'(i) < ({1'b0, off} + nb));
        end
    end

    assign be_o     = write_i ? mask : {BE_W{1'b1}};
    assign nbytes_o = nb;
    assign last_o   = (rem_i == REM_W'(nb)) || (&cur_addr_i[LINE_LSB-1:2]);

endmodule

// File: rtl/dma_beat_addr.sv
// Beat address register: loads the start address with bit 0 cleared, then
// advances to the next aligned dword after each beat.
module dma_beat_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= '0;
        end else if (load_i) begin
            cur_o <= {addr_i[ADDR_W-1:1], 1'b0};
        end else if (step_i) begin
            cur_o <= {cur_o[ADDR_W-1:2] + 1'b1, 2'b00};
        end
    end
endmodule

// File: rtl/dma_beat_remain.sv
// Remaining byte counter; a zero count request is loaded as the full span.
module dma_beat_remain #(
    parameter int CNT_W = 16,
    parameter int REM_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dec_i,
    input  logic [2:0]       dec_amt_i,
    output logic [REM_W-1:0] rem_o
);
    localparam logic [REM_W-1:0] FULL_SPAN = REM_W'(1) << CNT_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_o <= '0;
        end else if (load_i) begin
            rem_o <= (count_i == '0) ? FULL_SPAN : {1'b0, count_i};
        end else if (dec_i) begin
            rem_o <= rem_o - REM_W'(dec_amt_i);
        end
    end

    // R7: a beat never consumes more bytes than remain
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (REM_W'(dec_amt_i) <= rem_o) && (dec_amt_i != 3'd0));
endmodule

// File: rtl/dma_beat_gen.sv
module dma_beat_gen #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              beat_valid_o,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic [3:0]        beat_be_o,
    output logic              beat_last_o,
    output logic              burst_end_o,
    output logic [CNT_W:0]    rem_o,
    output logic              region_done_o
);
    import dma_beat_pkg::*;

    localparam int REM_W    = CNT_W + 1;
    localparam int LINE_LSB = $clog2(LINE_BYTES);

    beat_state_t       state_q, state_d;
    logic              wr_q;
    logic              load, step;
    logic [ADDR_W-1:0] cur_addr;
    logic [REM_W-1:0]  rem;
    be_t               lane_be;
    logic [2:0]        lane_nb;
    logic              lane_last;

    assign load = (state_q == ST_IDLE) && start_i;
    assign step = (state_q == ST_BEAT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                wr_q <= write_i;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_BEAT;
            ST_BEAT: if (lane_last) state_d = ST_END;
            ST_END:                 state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    dma_beat_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .addr_i (addr_i),
        .step_i (step),
        .cur_o  (cur_addr)
    );

    dma_beat_remain #(.CNT_W(CNT_W), .REM_W(REM_W)) u_remain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .count_i   (count_i),
        .dec_i     (step),
        .dec_amt_i (lane_nb),
        .rem_o     (rem)
    );

    dma_beat_lane #(.ADDR_W(ADDR_W), .REM_W(REM_W), .LINE_BYTES(LINE_BYTES)) u_lane (
        .cur_addr_i (cur_addr),
        .rem_i      (rem),
        .write_i    (wr_q),
        .be_o       (lane_be),
        .nbytes_o   (lane_nb),
        .last_o     (lane_last)
    );

    // Outputs
    always_comb begin
        busy_o        = 1'b0;
        beat_valid_o  = 1'b0;
        beat_addr_o   = '0;
        beat_be_o     = '0;
        beat_last_o   = 1'b0;
        burst_end_o   = 1'b0;
        region_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BEAT: begin
                busy_o       = 1'b1;
                beat_valid_o = 1'b1;
                beat_addr_o  = wr_q ? cur_addr : {cur_addr[ADDR_W-1:2], 2'b00};
                beat_be_o    = lane_be;
                beat_last_o  = lane_last;
            end
            ST_END: begin
                busy_o        = 1'b1;
                burst_end_o   = 1'b1;
                region_done_o = (rem == '0);
            end
            default: ;
        endcase
    end

    assign rem_o = rem;

    p_rd_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !wr_q |-> (beat_be_o == 4'hF) && (beat_addr_o[1:0] == 2'b00));

    p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid_o) && wr_q && beat_addr_o[1] |-> beat_be_o[1:0] == 2'b00);

    p_same_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !beat_last_o |=> beat_valid_o &&
            (beat_addr_o[ADDR_W-1:LINE_LSB] == $past(beat_addr_o[ADDR_W-1:LINE_LSB])));

    p_be_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> beat_be_o != 4'h0);

    p_last_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_last_o |=> !beat_valid_o && burst_end_o);

endmodule

// File: tb/dma_beat_gen_test.sv
module dma_beat_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        write_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [15:0] count_i = '0;
    logic        busy_o, beat_valid_o, beat_last_o, burst_end_o, region_done_o;
    logic [31:0] beat_addr_o;
    logic [3:0]  beat_be_o;
    logic [16:0] rem_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    dma_beat_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .addr_i(addr_i), .count_i(count_i), .busy_o(busy_o),
        .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o),
        .beat_be_o(beat_be_o), .beat_last_o(beat_last_o),
        .burst_end_o(burst_end_o), .rem_o(rem_o), .region_done_o(region_done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] off, input int nb);
        logic [3:0] m = '0;
        for (int i = 0; i < 4; i++) m[i] = (i >= off) && (i < off + nb);
        return m;
    endfunction

    // glitch: drive unrelated requests during the burst (R9)
    task automatic run_burst(input logic [31:0] a, input logic [15:0] c, input bit wr, input bit glitch);
        logic [31:0] m_addr;
        int m_rem, nb, beats, exp_beats, start_rem;
        bit last_exp, fin;
        logic [3:0] be_exp;
        logic [31:0] a_exp;
        @(negedge clk);
        start_i = 1'b1; write_i = wr; addr_i = a; count_i = c;
        m_addr = {a[31:1], 1'b0};
        start_rem = (c == 0) ? 65536 : int'(c);
        m_rem = start_rem;
        // expected beat count from the requirements
        begin
            logic [31:0] t = m_addr; int r = m_rem; bit done = 0;
            exp_beats = 0;
            while (!done) begin
                int n = (r < 4 - int'(t[1:0])) ? r : 4 - int'(t[1:0]);
                exp_beats++;
                r -= n;
                done = (r == 0) || (t[4:2] == 3'd7);
                t = {t[31:2] + 30'd1, 2'b00};
            end
        end
        beats = 0; fin = 0;
        @(negedge clk);
        if (glitch) begin
            start_i = 1'b1; write_i = ~wr; addr_i = a ^ 32'h0000_0044; count_i = c + 16'd7;
        end else begin
            start_i = 1'b0;
        end
        while (!fin) begin
            if (glitch && beats == 3) start_i = 1'b0;
            if (beat_valid_o) begin
                nb = (m_rem < 4 - int'(m_addr[1:0])) ? m_rem : 4 - int'(m_addr[1:0]);
                a_exp = wr ? m_addr : {m_addr[31:2], 2'b00};
                be_exp = wr ? exp_mask(m_addr[1:0], nb) : 4'hF;
                last_exp = (m_rem == nb) || (m_addr[4:2] == 3'd7);
                chk(beat_addr_o == a_exp, wr ? "R2 beat address" : "R1 beat address", beat_addr_o, a_exp);
                if (!wr)
                    chk(beat_be_o == be_exp, "R1 read enables", {28'd0, beat_be_o}, {28'd0, be_exp});
                else if (m_addr[1])
                    chk(beat_be_o == be_exp, "R2 word-offset enables", {28'd0, beat_be_o}, {28'd0, be_exp});
                else if (nb < 4)
                    chk(beat_be_o == be_exp, "R5 trailing enables", {28'd0, beat_be_o}, {28'd0, be_exp});
                else
                    chk(beat_be_o == be_exp, "R3 full enables", {28'd0, beat_be_o}, {28'd0, be_exp});
                chk(beat_last_o == last_exp, "R6 last flag", {31'd0, beat_last_o}, {31'd0, last_exp});
                m_rem -= nb;
                m_addr = {m_addr[31:2] + 30'd1, 2'b00};
                beats++;
            end else if (burst_end_o) begin
                chk(beats == exp_beats, glitch ? "R9 beats under ignored start" : "R4 beat count",
                    beats, exp_beats);
                chk(rem_o == 17'(m_rem), (c == 0) ? "R8 remainder from zero count" : "R7 remainder",
                    {15'd0, rem_o}, m_rem);
                chk(region_done_o == (m_rem == 0), "R7 done flag",
                    {31'd0, region_done_o}, {31'd0, m_rem == 0});
                fin = 1;
            end else begin
                chk(0, "R6 beat stream gap", {31'd0, beat_valid_o}, 32'd1);
                fin = 1;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(busy_o == 1'b0, "R10 idle after burst", {31'd0, busy_o}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy_o && !beat_valid_o && !burst_end_o && !region_done_o, "R10 reset state",
            {28'd0, busy_o, beat_valid_o, burst_end_o, region_done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !beat_valid_o, "R10 idle after reset", {30'd0, busy_o, beat_valid_o}, 32'd0);

        run_burst(32'h0000_1000, 16'd100, 1'b1, 1'b0);  // R3 full line
        run_burst(32'h0000_1000, 16'd32,  1'b1, 1'b0);  // R3 exact line, done
        run_burst(32'h0000_1002, 16'd40,  1'b0, 1'b0);  // R1 read word offset
        run_burst(32'h0000_1002, 16'd40,  1'b1, 1'b0);  // R2 write word offset
        run_burst(32'h0000_1003, 16'd1,   1'b1, 1'b0);  // R5 0100, bit 0 ignored
        run_burst(32'h0000_1002, 16'd2,   1'b1, 1'b0);  // R2 single beat
        for (int t = 1; t <= 3; t++)
            run_burst(32'h0000_2000, 16'(8 + t), 1'b1, 1'b0);  // R5 0001/0011/0111
        for (int s = 0; s < 8; s++)
            run_burst(32'h0000_3000 + 32'(s * 4), 16'd500, 1'b1, 1'b0);  // R4 line end
        run_burst(32'h0000_401C, 16'd0,   1'b1, 1'b0);  // R8
        run_burst(32'h0000_4000, 16'd0,   1'b0, 1'b0);  // R8 read
        run_burst(32'h0000_5000, 16'd64,  1'b1, 1'b1);  // R9

        for (int k = 0; k < 300; k++) begin
            logic [31:0] a = {$urandom()} & 32'hFFFF_FFFE;
            logic [15:0] c = ($urandom_range(0, 3) == 0) ? 16'($urandom()) : 16'($urandom_range(1, 40));
            run_burst(a, c, 1'($urandom_range(0, 1)), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule